// File: doc/BRIEF.md
# Flow Table Entry Read-Back Controller

This block fetches one flow table entry from an on-chip SRAM that is reachable only through an indirect register window. A client issues a command that carries an entry index. The controller writes a control word that holds the index and a request flag. It then polls the same control register until an acknowledge flag appears. After the acknowledge, it reads the entry as a run of 32-bit words from a data window and hands the whole entry back in a single response beat. If the acknowledge never comes within a bounded time, the response reports a timeout instead.

The table can be split between two lookup engines. Each engine has its own control register and its own data window in the register space. When the split is enabled, indices in the upper part of the SRAM range go to the second engine. Indices beyond the SRAM range live in external memory and are not read through the window. For these, the controller returns a bypass response at once and makes no register access. The poll interval and the timeout are counted in clock cycles. The entry length, the index width and the register layout are all parameters.

Top module: `entry_fetch_ctrl`

## Requirements
- R1: After reset, and again after a reset that interrupts a fetch, `cmd_ready` is 1, `rsp_valid` is 0, and neither `reg_wr` nor `reg_rd` is asserted.
- R2: An accepted in-range command produces exactly one register write, in the cycle after acceptance. It goes to offset 0 of the selected engine. Its data holds the index in bits [IDX_W-1:0], bit 31 (request) set, and every other bit 0.
- R3: An engine base address is `engine * ENG_STRIDE`. The second engine (base `ENG_STRIDE`) is used only when `dual_en` is 1 and the index is at or above `ENG0_ENTRIES`. Every other in-range index uses the first engine (base 0).
- R4: No data-window read (offset other than 0) happens before a control read has returned bit 30 (acknowledge) as 1.
- R5: The first control read comes in the cycle right after the write. Further control reads follow every `POLL_CYC` cycles, until one of them returns the acknowledge.
- R6: If the control read made `TIMEOUT_CYC` cycles after the first one still shows no acknowledge, the controller returns a response with `rsp_timeout` set. That response has no data reads and `rsp_data` is all zero. It arrives `TIMEOUT_CYC + 3` cycles after acceptance.
- R7: After the acknowledge, the controller reads words 0 to `ENTRY_WORDS-1` from offsets 1 to `ENTRY_WORDS`, one per cycle and in ascending order. Word k is returned in `rsp_data[32k+31:32k]`. The response comes `ENTRY_WORDS + 3 + (n-1)*POLL_CYC` cycles after acceptance, where n is the number of control reads.
- R8: An index at or above `SRAM_ENTRIES` gives a response with `rsp_bypass` set one cycle after acceptance. It makes no register access and `rsp_data` is all zero.
- R9: A command is taken only when `cmd_ready` is 1. While a fetch is running, `cmd_valid` is ignored: it causes no extra response and no extra register access.
- R10: Each accepted command gives exactly one response, and `rsp_valid` stays high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_en | input | 1 | Table split across two engines |
| cmd_valid | input | 1 | Read command present |
| cmd_index | input | IDX_W | Entry index to fetch |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | ADDR_W | Register word address |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid in the strobe cycle |
| rsp_valid | output | 1 | Response beat |
| rsp_timeout | output | 1 | Acknowledge never came |
| rsp_bypass | output | 1 | Index is outside the SRAM range |
| rsp_data | output | ENTRY_WORDS*32 | Entry words, word 0 in the low bits |

## Verification
The bench places the acknowledge just inside and just outside the timeout window. A design with an off-by-one in its elapsed counter would then either fail an entry that should succeed or pass one that should time out, and the fixed response latency would expose it. It probes the index boundaries at the engine split and at the SRAM limit, both with the split enabled and with it disabled. A wrong compare there would send the request to the other engine's registers, or start a handshake for an external index. A model that returns data only after the acknowledge catches early window reads and words read out of order. A command pulsed in the middle of a fetch, and a reset in the middle of a poll, catch a controller that restarts or keeps going when it should stay idle.

// File: rtl/efc_pkg.sv
package efc_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_POLL,
      ST_WAIT,
      ST_READ,
      ST_DONE
   } efc_state_e;
endpackage

// File: rtl/efc_route.sv
// Decodes an entry index into bypass / engine selection.
module efc_route #(
   parameter int IDX_W        = 16,
   parameter int SRAM_ENTRIES = 1024,
   parameter int ENG0_ENTRIES = 512,
   parameter int DUAL_ENGINE  = 1
) (
   input  logic [IDX_W-1:0] index_i,
   input  logic             dual_en,
   output logic             bypass_o,
   output logic             eng_o
);
   localparam logic [IDX_W:0] SRAM_LIM = (IDX_W+1)'(SRAM_ENTRIES);
   localparam logic [IDX_W:0] ENG0_LIM = (IDX_W+1)'(ENG0_ENTRIES);

   assign bypass_o = ({1'b0, index_i} >= SRAM_LIM);

   if (DUAL_ENGINE != 0) begin : g_dual
      assign eng_o = dual_en & ({1'b0, index_i} >= ENG0_LIM);
   end else begin : g_single
      assign eng_o = dual_en & 1'b0;
   end
endmodule

// File: rtl/efc_poll_timer.sv
// Elapsed-time and poll-interval counters for the acknowledge wait.
module efc_poll_timer #(
   parameter int POLL_CYC    = 1250,
   parameter int TIMEOUT_CYC = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic run_i,
   input  logic ivl_clr_i,
   input  logic ivl_run_i,
   output logic ivl_done_o,
   output logic expired_o
);
   localparam int EW = $clog2(TIMEOUT_CYC + 1);
   localparam int IW = $clog2(POLL_CYC);
   localparam logic [EW-1:0] TMO_V = EW'(TIMEOUT_CYC);
   localparam logic [IW-1:0] IVL_V = IW'(POLL_CYC - 2);

   logic [EW-1:0] elapsed_q;
   logic [IW-1:0] ivl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed_q <= '0;
      end else if (start_i) begin
         elapsed_q <= '0;
      end else if (run_i && (elapsed_q != TMO_V)) begin
         elapsed_q <= elapsed_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ivl_q <= '0;
      end else if (ivl_clr_i) begin
         ivl_q <= '0;
      end else if (ivl_run_i) begin
         ivl_q <= ivl_q + 1'b1;
      end
   end

   assign expired_o  = (elapsed_q >= TMO_V);
   assign ivl_done_o = (ivl_q == IVL_V);
endmodule

// File: rtl/efc_word_buf.sv
// Entry capture buffer, one register per word.
module efc_word_buf #(
   parameter int WORDS = 20,
   parameter int W     = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 cap_i,
   input  logic [$clog2(WORDS)-1:0] sel_i,
   input  logic [W-1:0]         din_i,
   output logic [WORDS*W-1:0]   data_o
);
   localparam int SW = $clog2(WORDS);

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (clr_i) begin
            q <= '0;
         end else if (cap_i && (sel_i == SW'(k))) begin
            q <= din_i;
         end
      end
      assign data_o[k*W +: W] = q;
   end
endmodule

// File: rtl/entry_fetch_ctrl.sv
module entry_fetch_ctrl
   import efc_pkg::*;
#(
   parameter int IDX_W        = 16,
   parameter int SRAM_ENTRIES = 1024,
   parameter int ENG0_ENTRIES = 512,
   parameter int DUAL_ENGINE  = 1,
   parameter int ENTRY_WORDS  = 20,
   parameter int ENG_STRIDE   = 32,
   parameter int ADDR_W       = 6,
   parameter int POLL_CYC     = 1250,
   parameter int TIMEOUT_CYC  = 12500,
   parameter int REQ_BIT      = 31,
   parameter int ACK_BIT      = 30
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          dual_en,
   input  logic                          cmd_valid,
   input  logic [IDX_W-1:0]              cmd_index,
   output logic                          cmd_ready,
   output logic                          reg_wr,
   output logic                          reg_rd,
   output logic [ADDR_W-1:0]             reg_addr,
   output logic [WORD_W-1:0]             reg_wdata,
   input  logic [WORD_W-1:0]             reg_rdata,
   output logic                          rsp_valid,
   output logic                          rsp_timeout,
   output logic                          rsp_bypass,
   output logic [ENTRY_WORDS*WORD_W-1:0] rsp_data
);
   localparam int WCW      = $clog2(ENTRY_WORDS);
   localparam int ADDR_MIN = $clog2(2 * ENG_STRIDE);
   localparam logic [WCW-1:0]    LAST_WORD = WCW'(ENTRY_WORDS - 1);
   localparam logic [ADDR_W-1:0] ENG1_BASE = ADDR_W'(ENG_STRIDE);

   // elaboration-time parameter checks
   if (POLL_CYC < 2) begin : g_chk_poll
      $error("POLL_CYC must be at least 2");
   end
   if (TIMEOUT_CYC < POLL_CYC) begin : g_chk_tmo
      $error("TIMEOUT_CYC must not be below POLL_CYC");
   end
   if (ENG_STRIDE <= ENTRY_WORDS) begin : g_chk_stride
      $error("ENG_STRIDE must exceed ENTRY_WORDS");
   end
   if (ADDR_W < ADDR_MIN) begin : g_chk_addr
      $error("ADDR_W too narrow for two engine windows");
   end
   if (ENG0_ENTRIES > SRAM_ENTRIES) begin : g_chk_split
      $error("ENG0_ENTRIES exceeds SRAM_ENTRIES");
   end
   if ((IDX_W > ACK_BIT) || (IDX_W > REQ_BIT) || (REQ_BIT == ACK_BIT) ||
       (REQ_BIT >= WORD_W) || (ACK_BIT >= WORD_W)) begin : g_chk_bits
      $error("control word layout overlaps");
   end
   if (ENTRY_WORDS < 2) begin : g_chk_words
      $error("ENTRY_WORDS must be at least 2");
   end

   efc_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             eng_q;
   logic             tmo_q;
   logic             byp_q;
   logic [WCW-1:0]   word_q;

   logic rt_bypass, rt_eng;
   logic ivl_done, expired;
   logic accept;

   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_ready && cmd_valid;

   efc_route #(
      .IDX_W       (IDX_W),
      .SRAM_ENTRIES(SRAM_ENTRIES),
      .ENG0_ENTRIES(ENG0_ENTRIES),
      .DUAL_ENGINE (DUAL_ENGINE)
   ) u_route (
      .index_i (cmd_index),
      .dual_en (dual_en),
      .bypass_o(rt_bypass),
      .eng_o   (rt_eng)
   );

   efc_poll_timer #(
      .POLL_CYC   (POLL_CYC),
      .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (state_q == ST_REQ),
      .run_i     ((state_q == ST_POLL) || (state_q == ST_WAIT)),
      .ivl_clr_i (state_q == ST_POLL),
      .ivl_run_i (state_q == ST_WAIT),
      .ivl_done_o(ivl_done),
      .expired_o (expired)
   );

   efc_word_buf #(
      .WORDS(ENTRY_WORDS),
      .W    (WORD_W)
   ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (accept),
      .cap_i (state_q == ST_READ),
      .sel_i (word_q),
      .din_i (reg_rdata),
      .data_o(rsp_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         eng_q   <= 1'b0;
         tmo_q   <= 1'b0;
         byp_q   <= 1'b0;
         word_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  idx_q <= cmd_index;
                  eng_q <= rt_eng;
                  tmo_q <= 1'b0;
                  byp_q <= rt_bypass;
                  state_q <= rt_bypass ? ST_DONE : ST_REQ;
               end
            end
            ST_REQ: state_q <= ST_POLL;
            ST_POLL: begin
               if (reg_rdata[ACK_BIT]) begin
                  word_q  <= '0;
                  state_q <= ST_READ;
               end else if (expired) begin
                  tmo_q   <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (ivl_done) state_q <= ST_POLL;
            end
            ST_READ: begin
               word_q <= word_q + 1'b1;
               if (word_q == LAST_WORD) state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      reg_wr    = 1'b0;
      reg_rd    = 1'b0;
      reg_wdata = '0;
      reg_addr  = eng_q ? ENG1_BASE : '0;
      case (state_q)
         ST_REQ: begin
            reg_wr                = 1'b1;
            reg_wdata[IDX_W-1:0]  = idx_q;
            reg_wdata[REQ_BIT]    = 1'b1;
         end
         ST_POLL: reg_rd = 1'b1;
         ST_READ: begin
            reg_rd   = 1'b1;
            reg_addr = (eng_q ? ENG1_BASE : '0) + ADDR_W'(word_q) + ADDR_W'(1);
         end
         default: ;
      endcase
   end

   assign rsp_valid   = (state_q == ST_DONE);
   assign rsp_timeout = rsp_valid && tmo_q;
   assign rsp_bypass  = rsp_valid && byp_q;
endmodule

// File: rtl/efc_checker.sv
module efc_checker #(
   parameter int ADDR_W     = 6,
   parameter int ENG_STRIDE = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              wdata_req,
   input logic              rdata_ack,
   input logic              rsp_valid,
   input logic              rsp_timeout,
   input logic              rsp_bypass
);
   logic [ADDR_W-1:0] off;
   logic              ack_seen;

   assign off = reg_addr % ADDR_W'(ENG_STRIDE);

   always_ff @(posedge clk) begin
      if (!rst_n)                             ack_seen <= 1'b0;
      else if (reg_wr)                        ack_seen <= 1'b0;
      else if (reg_rd && off == '0 && rdata_ack) ack_seen <= 1'b1;
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!reg_wr && !reg_rd));

   p_req_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (wdata_req && off == '0));

   p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   p_no_early_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && off != '0) |-> ack_seen);

   p_timeout_after_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_timeout) |-> ($past(reg_rd) && !$past(rdata_ack)));

   p_kind_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_timeout && rsp_bypass));

   p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && !rsp_valid) |=> !cmd_ready);

   p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && cmd_ready));
endmodule

bind entry_fetch_ctrl efc_checker #(
   .ADDR_W    (ADDR_W),
   .ENG_STRIDE(ENG_STRIDE)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_ready  (cmd_ready),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .wdata_req  (reg_wdata[REQ_BIT]),
   .rdata_ack  (reg_rdata[ACK_BIT]),
   .rsp_valid  (rsp_valid),
   .rsp_timeout(rsp_timeout),
   .rsp_bypass (rsp_bypass)
);

// File: tb/test_entry_fetch_ctrl.sv
`timescale 1ns/1ps
module test_entry_fetch_ctrl;
   localparam int IDX_W  = 8;
   localparam int SRAM_N = 16;
   localparam int ENG0_N = 8;
   localparam int WORDS  = 20;
   localparam int STRIDE = 32;
   localparam int AW     = 6;
   localparam int POLL   = 4;
   localparam int TMO    = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dual_en = 1'b0;
   logic cmd_valid = 1'b0;
   logic [IDX_W-1:0] cmd_index = '0;
   logic cmd_ready, reg_wr, reg_rd, rsp_valid, rsp_timeout, rsp_bypass;
   logic [AW-1:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [WORDS*32-1:0] rsp_data;

   always #4 clk = ~clk;

   entry_fetch_ctrl #(
      .IDX_W(IDX_W), .SRAM_ENTRIES(SRAM_N), .ENG0_ENTRIES(ENG0_N), .DUAL_ENGINE(1),
      .ENTRY_WORDS(WORDS), .ENG_STRIDE(STRIDE), .ADDR_W(AW),
      .POLL_CYC(POLL), .TIMEOUT_CYC(TMO), .REQ_BIT(31), .ACK_BIT(30)
   ) i_entry_fetch_ctrl (
      .clk(clk), .rst_n(rst_n), .dual_en(dual_en), .cmd_valid(cmd_valid),
      .cmd_index(cmd_index), .cmd_ready(cmd_ready), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_bypass(rsp_bypass),
      .rsp_data(rsp_data)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int e, input int i, input int w);
      return {4'hA, 3'b0, 1'(e), 8'(i), 8'h5C, 8'(w)};
   endfunction

   // SRAM window model: acknowledge after a programmable delay
   int  ack_delay = 0;
   int  acnt = 0;
   bit  pend = 1'b0;
   int  m_weng = 0;
   int  m_widx = 0;
   logic m_acked;
   assign m_acked = pend && (acnt >= ack_delay);

   always @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         acnt <= 0;
      end else if (reg_wr) begin
         pend   <= 1'b1;
         acnt   <= 0;
         m_weng <= int'(reg_addr) / STRIDE;
         m_widx <= int'(reg_wdata[7:0]);
      end else if (acnt < 255) begin
         acnt <= acnt + 1;
      end
   end

   always_comb begin
      int off;
      int e;
      off = int'(reg_addr) % STRIDE;
      e   = int'(reg_addr) / STRIDE;
      if (off == 0) reg_rdata = {1'b0, (m_acked && e == m_weng), 30'b0};
      else          reg_rdata = pat(e, m_widx, off - 1);
   end

   // bus monitor, sampled at the rising edge
   int cyc = 0;
   int m_wr = 0, m_polls = 0, m_rd = 0, m_rsp = 0;
   int m_space_err = 0, m_early = 0, m_order_err = 0, m_last_poll = 0;
   int m_waddr = 0;
   logic [31:0] m_wdata = '0;

   always @(posedge clk) begin
      cyc++;
      if (rst_n) begin
         if (reg_wr) begin
            m_wr++;
            m_waddr = int'(reg_addr);
            m_wdata = reg_wdata;
         end
         if (reg_rd) begin
            if (int'(reg_addr) % STRIDE == 0) begin
               if (m_polls > 0 && (cyc - m_last_poll) != POLL) m_space_err++;
               m_polls++;
               m_last_poll = cyc;
            end else begin
               if (!m_acked) m_early++;
               if (int'(reg_addr) != m_waddr + m_rd + 1) m_order_err++;
               m_rd++;
            end
         end
         if (rsp_valid) m_rsp++;
      end
   end

   task automatic clr_mon();
      m_wr = 0; m_polls = 0; m_rd = 0; m_rsp = 0;
      m_space_err = 0; m_early = 0; m_order_err = 0;
   endtask

   // kind: 0 = entry returned, 1 = timeout, 2 = bypass
   task automatic run_cmd(input int idx, input int dual, input int dly,
                          input int exp_eng, input int kind);
      int lat;
      int n;
      int exp_lat;
      int bad;
      ack_delay = dly;
      dual_en   = dual[0];
      cmd_index = IDX_W'(idx);
      cmd_valid = 1'b1;
      chk(cmd_ready == 1'b1, "R9 ready before command", cmd_ready, 1);
      clr_mon();
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 300) begin
         @(negedge clk);
         lat++;
      end
      if (kind == 0) begin
         n = (dly + POLL - 1) / POLL + 1;
         exp_lat = WORDS + 3 + (n - 1) * POLL;
      end else if (kind == 1) begin
         n = TMO / POLL + 1;
         exp_lat = TMO + 3;
      end else begin
         n = 0;
         exp_lat = 1;
      end
      chk(lat == exp_lat, "R7 R6 R8 response latency", lat, exp_lat);
      chk(rsp_timeout == (kind == 1), "R6 timeout flag", rsp_timeout, kind == 1);
      chk(rsp_bypass == (kind == 2), "R8 bypass flag", rsp_bypass, kind == 2);
      chk(m_polls == n, "R5 number of control reads", m_polls, n);
      chk(m_space_err == 0, "R5 poll spacing", m_space_err, 0);
      chk(m_early == 0, "R4 data read before acknowledge", m_early, 0);
      if (kind == 2) begin
         chk(m_wr == 0, "R8 no register write", m_wr, 0);
      end else begin
         chk(m_wr == 1, "R2 one control write", m_wr, 1);
         chk(m_waddr == exp_eng * STRIDE, "R3 engine control address", m_waddr, exp_eng * STRIDE);
         chk(m_wdata == ({1'b1, 31'b0} | 32'(idx)), "R2 control word", m_wdata,
             {1'b1, 31'b0} | 32'(idx));
      end
      bad = -1;
      for (int k = 0; k < WORDS; k++) begin
         logic [31:0] exp_w;
         exp_w = (kind == 0) ? pat(exp_eng, idx, k) : 32'h0;
         if (bad < 0 && rsp_data[k*32 +: 32] != exp_w) bad = k;
      end
      chk(m_rd == ((kind == 0) ? WORDS : 0), "R7 data read count", m_rd, (kind == 0) ? WORDS : 0);
      chk(m_order_err == 0, "R7 data read order", m_order_err, 0);
      chk(bad < 0, "R7 response words", bad, -1);
      @(negedge clk);
      chk(rsp_valid == 1'b0 && m_rsp == 1, "R10 single response pulse", m_rsp, 1);
   endtask

   // idx, dual, delay, expected engine, expected kind
   localparam logic [19:0] VEC [0:8] = '{
      {8'd3,   1'b1, 8'd0,   1'b0, 2'd0},
      {8'd8,   1'b1, 8'd5,   1'b1, 2'd0},
      {8'd8,   1'b0, 8'd4,   1'b0, 2'd0},
      {8'd15,  1'b1, 8'd40,  1'b1, 2'd0},
      {8'd7,   1'b1, 8'd41,  1'b0, 2'd1},
      {8'd16,  1'b1, 8'd0,   1'b0, 2'd2},
      {8'd255, 1'b0, 8'd0,   1'b0, 2'd2},
      {8'd12,  1'b0, 8'd13,  1'b0, 2'd0},
      {8'd0,   1'b0, 8'd200, 1'b0, 2'd1}
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
      chk(!reg_wr && !reg_rd, "R1 bus idle after reset", {reg_wr, reg_rd}, 0);

      for (int v = 0; v < 9; v++) begin
         run_cmd(int'(VEC[v][19:12]), int'(VEC[v][11]), int'(VEC[v][10:3]),
                 int'(VEC[v][2]), int'(VEC[v][1:0]));
      end

      // R9: command pulsed during a running fetch is ignored
      ack_delay = 10;
      dual_en   = 1'b1;
      cmd_index = 8'd2;
      cmd_valid = 1'b1;
      clr_mon();
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(cmd_ready == 1'b0, "R9 busy during fetch", cmd_ready, 0);
      cmd_index = 8'd9;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      chk(rsp_data[31:0] == pat(0, 2, 0), "R9 response of first command", rsp_data[31:0], pat(0, 2, 0));
      repeat (30) @(negedge clk);
      chk(m_rsp == 1 && m_wr == 1, "R9 ignored command made no access", m_rsp * 16 + m_wr, 17);

      // R1: reset in the middle of polling
      ack_delay = 100;
      cmd_index = 8'd1;
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R1 idle after mid-fetch reset",
          {cmd_ready, rsp_valid}, 2'b10);
      chk(!reg_wr && !reg_rd, "R1 bus idle after mid-fetch reset", {reg_wr, reg_rd}, 0);
      run_cmd(10, 1, 2, 1, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule